// File: doc/BRIEF.md
# Self-Timed Nonvolatile Write Controller

This block is the back end behind a serial programming port. It holds a small program array organized as 16-bit words, a byte-wide data array, and a one-page staging buffer for the program array. A front end gives it single-cycle commands on one command bus. Commands can stage bytes into the buffer, commit the buffer to one program page, write one data byte, erase both arrays, or read either array. Every commit, byte write or erase starts a busy timer whose length is set in system clocks by a parameter, so a simulation can run with short times.

Read data also serves as the completion status. While a timed operation runs, any read of a location that the operation touches returns 0xFF. Once the timer expires, the new contents are stored and the same read returns them. A caller therefore polls any address in the page being committed, or the byte being written, until the value it expects comes back. A byte write needs no earlier erase, because the new value replaces the old one whatever the old bits were. If a staging, commit, write or erase command arrives while the timer runs, it is discarded and an error flag is set. The flag stays set until reset.

Top module: `nvm_timed_writer`

## Requirements
- R1: After reset, busy, err_sticky and rd_valid are 0, and every location of both arrays reads 0xFF.
- R2: cmd_op 0 stages cmd_wdata into the page buffer word at offset cmd_addr[PAGE_LOG2-1:0]. cmd_hi=1 selects the high byte and cmd_hi=0 the low byte. Staged data does not show in the program array before a commit completes.
- R3: cmd_op 1 commits the buffer to program page cmd_addr[WORD_AW-1:PAGE_LOG2]. busy rises on the next cycle and stays high for exactly T_PAGE cycles. At the end, every word of the page takes its buffer value in the same cycle.
- R4: During a commit, a program read (cmd_op 4, word cmd_addr, byte cmd_hi) of any word in the target page returns 0xFF. Reads of other pages return their stored value.
- R5: cmd_op 2 writes cmd_wdata to data address cmd_addr, with busy high for exactly T_BYTE cycles. A data read (cmd_op 5) of that address returns 0xFF until the end, and other addresses read normally. The new value replaces any previous value, with no erase needed first.
- R6: cmd_op 3 sets both arrays to 0xFF, with busy high for exactly T_ERASE cycles. Every read returns 0xFF while it runs.
- R7: A command with cmd_op 0 to 3 that arrives while busy is high has no effect on the arrays, the buffer or the timer. It sets err_sticky on the next cycle, and err_sticky stays set until reset.
- R8: Each read command, busy or not, gives one rd_valid pulse with rd_data on the following cycle.
- R9: When a commit completes, the page buffer returns to all 0xFF. A later commit with no staging writes 0xFF to its page.
- R10: cmd_op 6 and 7 are ignored. They produce no rd_valid, start no timer and set no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code (see R2 to R10) |
| cmd_addr | input | ADDR_W | Word address (program) or byte address (data) |
| cmd_hi | input | 1 | High-byte select for program staging and reads |
| cmd_wdata | input | 8 | Byte to stage or write |
| busy | output | 1 | Timed operation in progress |
| err_sticky | output | 1 | A mutating command was dropped while busy |
| rd_valid | output | 1 | Read result valid this cycle |
| rd_data | output | 8 | Read result, 0xFF for locations being written |

## Verification
A command is captured on the rising edge that follows its strobe. busy therefore shows it one cycle after the strobe, and rd_valid/rd_data carry a read's answer in that same cycle. The array update and the fall of busy happen on one edge, T cycles after acceptance, so a read strobed in the last busy cycle still gets 0xFF and one strobed a cycle later gets the new value. The bench drives and samples on falling edges. It counts the busy samples that follow each accepted command and adds the cycles spent on intermediate reads or dropped commands, so each measured duration must equal the parameter exactly.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  timeunit 1ns; timeprecision 100ps;

  localparam logic [7:0] NVM_BLANK = 8'hFF;

  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_COMMIT  = 3'd1,
    OP_BYTE_WR = 3'd2,
    OP_ERASE   = 3'd3,
    OP_RD_PROG = 3'd4,
    OP_RD_DATA = 3'd5
  } nvm_op_e;

  typedef enum logic [1:0] {
    JOB_NONE  = 2'd0,
    JOB_PAGE  = 2'd1,
    JOB_BYTE  = 2'd2,
    JOB_ERASE = 2'd3
  } nvm_job_e;

  // commands that change stored state
  function automatic logic op_mutates(logic [2:0] op);
    return op <= 3'd3;
  endfunction

  function automatic logic op_timed(logic [2:0] op);
    return (op == OP_COMMIT) || (op == OP_BYTE_WR) || (op == OP_ERASE);
  endfunction

  function automatic logic op_reads(logic [2:0] op);
    return (op == OP_RD_PROG) || (op == OP_RD_DATA);
  endfunction

  function automatic nvm_job_e job_for(logic [2:0] op);
    case (op)
      OP_COMMIT:  return JOB_PAGE;
      OP_BYTE_WR: return JOB_BYTE;
      OP_ERASE:   return JOB_ERASE;
      default:    return JOB_NONE;
    endcase
  endfunction
endpackage

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer
  import nvm_pkg::*;
#(
  parameter int unsigned T_PAGE  = 900000,
  parameter int unsigned T_BYTE  = 1800000,
  parameter int unsigned T_ERASE = 1800000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  nvm_job_e start_job,
  output logic     busy,
  output nvm_job_e job,
  output logic     done
);
  timeunit 1ns; timeprecision 100ps;

  localparam int unsigned T_PB  = (T_PAGE > T_BYTE) ? T_PAGE : T_BYTE;
  localparam int unsigned T_MAX = (T_PB > T_ERASE) ? T_PB : T_ERASE;
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  logic [CNT_W-1:0] cnt_q;
  nvm_job_e         job_q;

  // remaining cycles after the accepting edge
  function automatic logic [CNT_W-1:0] span_for(nvm_job_e j);
    case (j)
      JOB_PAGE:  return CNT_W'(T_PAGE - 1);
      JOB_BYTE:  return CNT_W'(T_BYTE - 1);
      JOB_ERASE: return CNT_W'(T_ERASE - 1);
      default:   return '0;
    endcase
  endfunction

  assign busy = (job_q != JOB_NONE);
  assign done = busy && (cnt_q == '0);
  assign job  = job_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      job_q <= JOB_NONE;
      cnt_q <= '0;
    end else if (start && !busy) begin
      job_q <= start_job;
      cnt_q <= span_for(start_job);
    end else if (done) begin
      job_q <= JOB_NONE;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nvm_prog_store.sv
module nvm_prog_store
  import nvm_pkg::*;
#(
  parameter  int unsigned PAGE_LOG2  = 2,
  parameter  int unsigned PAGES_LOG2 = 3,
  localparam int unsigned WORD_AW    = PAGE_LOG2 + PAGES_LOG2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en,
  input  logic [PAGE_LOG2-1:0]  load_off,
  input  logic                  load_hi,
  input  logic [7:0]            load_byte,
  input  logic                  commit_en,
  input  logic [PAGES_LOG2-1:0] commit_page,
  input  logic                  erase_en,
  input  logic [WORD_AW-1:0]    rd_word,
  input  logic                  rd_hi,
  output logic [7:0]            rd_byte
);
  timeunit 1ns; timeprecision 100ps;

  localparam int unsigned PAGE_WORDS = 1 << PAGE_LOG2;
  localparam int unsigned WORDS      = 1 << WORD_AW;

  function automatic logic [PAGES_LOG2-1:0] page_of(logic [WORD_AW-1:0] a);
    return a[WORD_AW-1:PAGE_LOG2];
  endfunction

  function automatic logic [7:0] pick_byte(logic [15:0] w, logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

  logic [15:0] pbuf_w [PAGE_WORDS];
  logic [15:0] mem_w  [WORDS];

  for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_pbuf
    logic [15:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= {2{NVM_BLANK}};
      end else if (commit_en) begin
        slot_q <= {2{NVM_BLANK}};
      end else if (load_en && (load_off == PAGE_LOG2'(i))) begin
        if (load_hi) slot_q[15:8] <= load_byte;
        else         slot_q[7:0]  <= load_byte;
      end
    end
    assign pbuf_w[i] = slot_q;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [15:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= {2{NVM_BLANK}};
      end else if (erase_en) begin
        cell_q <= {2{NVM_BLANK}};
      end else if (commit_en && (page_of(WORD_AW'(w)) == commit_page)) begin
        cell_q <= pbuf_w[w % PAGE_WORDS];
      end
    end
    assign mem_w[w] = cell_q;
  end

  assign rd_byte = pick_byte(mem_w[rd_word], rd_hi);
endmodule

// File: rtl/nvm_data_store.sv
module nvm_data_store
  import nvm_pkg::*;
#(
  parameter int unsigned DATA_AW = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_AW-1:0] wr_addr,
  input  logic [7:0]         wr_byte,
  input  logic               erase_en,
  input  logic [DATA_AW-1:0] rd_addr,
  output logic [7:0]         rd_byte
);
  timeunit 1ns; timeprecision 100ps;

  localparam int unsigned BYTES = 1 << DATA_AW;

  logic [7:0] mem_w [BYTES];

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic [7:0] cell_q;
    // replacement regardless of old bits models erase-then-write
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= NVM_BLANK;
      end else if (erase_en) begin
        cell_q <= NVM_BLANK;
      end else if (wr_en && (wr_addr == DATA_AW'(b))) begin
        cell_q <= wr_byte;
      end
    end
    assign mem_w[b] = cell_q;
  end

  assign rd_byte = mem_w[rd_addr];
endmodule

// File: rtl/nvm_timed_writer.sv
module nvm_timed_writer
  import nvm_pkg::*;
#(
  parameter  int unsigned PAGE_LOG2  = 2,
  parameter  int unsigned PAGES_LOG2 = 3,
  parameter  int unsigned DATA_AW    = 5,
  parameter  int unsigned T_PAGE     = 900000,
  parameter  int unsigned T_BYTE     = 1800000,
  parameter  int unsigned T_ERASE    = 1800000,
  localparam int unsigned WORD_AW    = PAGE_LOG2 + PAGES_LOG2,
  localparam int unsigned ADDR_W     = (WORD_AW > DATA_AW) ? WORD_AW : DATA_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_hi,
  input  logic [7:0]        cmd_wdata,
  output logic              busy,
  output logic              err_sticky,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  timeunit 1ns; timeprecision 100ps;

  // named internal events
  logic     busy_w;
  logic     tmr_done;
  nvm_job_e job_w;
  logic     req_read, req_drop, req_start, req_load;
  logic     page_apply, byte_apply, erase_apply;

  logic [WORD_AW-1:0] cmd_word;
  logic [DATA_AW-1:0] cmd_daddr;
  assign cmd_word  = cmd_addr[WORD_AW-1:0];
  assign cmd_daddr = cmd_addr[DATA_AW-1:0];

  function automatic logic [PAGES_LOG2-1:0] page_of(logic [WORD_AW-1:0] a);
    return a[WORD_AW-1:PAGE_LOG2];
  endfunction

  function automatic logic prog_hidden(nvm_job_e j, logic [PAGES_LOG2-1:0] tgt,
                                       logic [WORD_AW-1:0] a);
    return (j == JOB_ERASE) || ((j == JOB_PAGE) && (page_of(a) == tgt));
  endfunction

  function automatic logic data_hidden(nvm_job_e j, logic [DATA_AW-1:0] tgt,
                                       logic [DATA_AW-1:0] a);
    return (j == JOB_ERASE) || ((j == JOB_BYTE) && (a == tgt));
  endfunction

  assign req_read  = cmd_valid && op_reads(cmd_op);
  assign req_drop  = cmd_valid && op_mutates(cmd_op) && busy_w;
  assign req_start = cmd_valid && op_timed(cmd_op) && !busy_w;
  assign req_load  = cmd_valid && (cmd_op == OP_LOAD) && !busy_w;

  nvm_busy_timer #(
    .T_PAGE(T_PAGE), .T_BYTE(T_BYTE), .T_ERASE(T_ERASE)
  ) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(req_start), .start_job(job_for(cmd_op)),
    .busy(busy_w), .job(job_w), .done(tmr_done)
  );

  // operation target captured at acceptance
  logic [PAGES_LOG2-1:0] tgt_page_q;
  logic [DATA_AW-1:0]    tgt_addr_q;
  logic [7:0]            tgt_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_page_q <= '0;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
    end else if (req_start) begin
      tgt_page_q <= page_of(cmd_word);
      tgt_addr_q <= cmd_daddr;
      tgt_data_q <= cmd_wdata;
    end
  end

  assign page_apply  = tmr_done && (job_w == JOB_PAGE);
  assign byte_apply  = tmr_done && (job_w == JOB_BYTE);
  assign erase_apply = tmr_done && (job_w == JOB_ERASE);

  logic [7:0] prog_rd, data_rd;

  nvm_prog_store #(
    .PAGE_LOG2(PAGE_LOG2), .PAGES_LOG2(PAGES_LOG2)
  ) u_prog (
    .clk(clk), .rst_n(rst_n),
    .load_en(req_load), .load_off(cmd_word[PAGE_LOG2-1:0]),
    .load_hi(cmd_hi), .load_byte(cmd_wdata),
    .commit_en(page_apply), .commit_page(tgt_page_q),
    .erase_en(erase_apply),
    .rd_word(cmd_word), .rd_hi(cmd_hi), .rd_byte(prog_rd)
  );

  nvm_data_store #(
    .DATA_AW(DATA_AW)
  ) u_data (
    .clk(clk), .rst_n(rst_n),
    .wr_en(byte_apply), .wr_addr(tgt_addr_q), .wr_byte(tgt_data_q),
    .erase_en(erase_apply),
    .rd_addr(cmd_daddr), .rd_byte(data_rd)
  );

  logic [7:0] rd_next;
  always_comb begin
    if (cmd_op == OP_RD_PROG)
      rd_next = prog_hidden(job_w, tgt_page_q, cmd_word) ? NVM_BLANK : prog_rd;
    else
      rd_next = data_hidden(job_w, tgt_addr_q, cmd_daddr) ? NVM_BLANK : data_rd;
  end

  logic       rd_valid_q, err_q;
  logic [7:0] rd_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      err_q      <= 1'b0;
    end else begin
      rd_valid_q <= req_read;
      if (req_read) rd_data_q <= rd_next;
      if (req_drop) err_q <= 1'b1;
    end
  end

  assign busy       = busy_w;
  assign err_sticky = err_q;
  assign rd_valid   = rd_valid_q;
  assign rd_data    = rd_data_q;
endmodule

// File: rtl/nvm_timed_writer_sva.sv
module nvm_timed_writer_sva
  import nvm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       busy,
  input logic       err_sticky,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       tmr_done,
  input logic [1:0] job
);
  timeunit 1ns; timeprecision 100ps;

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && (cmd_op inside {3'd1, 3'd2, 3'd3})) |=> busy); // R3
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tmr_done) |=> busy); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_done |=> !busy); // R5
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && (cmd_op <= 3'd3)) |=> err_sticky); // R7
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky); // R7
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op inside {3'd4, 3'd5})) |=> rd_valid); // R8
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && (cmd_op inside {3'd4, 3'd5})) |=> !rd_valid); // R10
  AST_ERASE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (job == JOB_ERASE) && cmd_valid && (cmd_op inside {3'd4, 3'd5}))
      |=> (rd_data == 8'hFF)); // R6
endmodule

bind nvm_timed_writer nvm_timed_writer_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .err_sticky(err_sticky), .rd_valid(rd_valid), .rd_data(rd_data),
  .tmr_done(tmr_done), .job(job_w)
);

// File: tb/nvm_timed_writer_test.sv
module nvm_timed_writer_test;
  timeunit 1ns; timeprecision 100ps;

  localparam int TP = 20, TB = 30, TE = 40;
  localparam logic [2:0] C_LD = 3'd0, C_CM = 3'd1, C_BW = 3'd2, C_ER = 3'd3,
                         C_RP = 3'd4, C_RD = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [4:0] cmd_addr = '0;
  logic       cmd_hi = 1'b0;
  logic [7:0] cmd_wdata = '0;
  logic       busy, err_sticky, rd_valid;
  logic [7:0] rd_data;

  always #2.5 clk = ~clk;

  nvm_timed_writer #(
    .PAGE_LOG2(2), .PAGES_LOG2(3), .DATA_AW(5),
    .T_PAGE(TP), .T_BYTE(TB), .T_ERASE(TE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_hi(cmd_hi), .cmd_wdata(cmd_wdata),
    .busy(busy), .err_sticky(err_sticky), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one command; returns after the capturing edge, at a falling edge
  task automatic issue(logic [2:0] op, logic [4:0] a, logic hi, logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_hi = hi; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read_chk(logic [2:0] op, logic [4:0] a, logic hi, logic [7:0] exp,
                          string req, string what);
    issue(op, a, hi, 8'h00);
    check(req, {what, " valid"}, 32'(rd_valid), 32'd1);
    check(req, what, 32'(rd_data), 32'(exp));
  endtask

  task automatic busy_left(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    check("R1", "busy", 32'(busy), 0);
    check("R1", "err", 32'(err_sticky), 0);
    check("R1", "rd_valid", 32'(rd_valid), 0);
    read_chk(C_RP, 5'd0, 1'b0, 8'hFF, "R1", "prog w0 lo");
    read_chk(C_RP, 5'd31, 1'b1, 8'hFF, "R1", "prog w31 hi");
    read_chk(C_RD, 5'd9, 1'b0, 8'hFF, "R8", "data 9");
  endtask

  task automatic t_page_commit();
    int c;
    for (int i = 0; i < 4; i++) begin
      issue(C_LD, 5'(4 + i), 1'b0, 8'(8'h10 + i));
      issue(C_LD, 5'(4 + i), 1'b1, 8'(8'h80 + i));
    end
    read_chk(C_RP, 5'd5, 1'b0, 8'hFF, "R2", "staged not visible");
    issue(C_CM, 5'd6, 1'b0, 8'h00);
    check("R3", "busy after commit", 32'(busy), 1);
    read_chk(C_RP, 5'd4, 1'b1, 8'hFF, "R4", "poll w4 hi");
    read_chk(C_RP, 5'd7, 1'b0, 8'hFF, "R4", "poll w7 lo");
    busy_left(c);
    check("R3", "page busy cycles", 32'(c + 2), 32'(TP));
    for (int i = 0; i < 4; i++) begin
      read_chk(C_RP, 5'(4 + i), 1'b0, 8'(8'h10 + i), "R3", "page lo");
      read_chk(C_RP, 5'(4 + i), 1'b1, 8'(8'h80 + i), "R3", "page hi");
    end
  endtask

  task automatic t_other_page();
    int c;
    issue(C_LD, 5'd2, 1'b0, 8'h3C);
    issue(C_CM, 5'd1, 1'b0, 8'h00);
    read_chk(C_RP, 5'd5, 1'b0, 8'h11, "R4", "other page readable");
    read_chk(C_RP, 5'd2, 1'b0, 8'hFF, "R4", "target page hidden");
    busy_left(c);
    read_chk(C_RP, 5'd2, 1'b0, 8'h3C, "R3", "w2 lo");
    read_chk(C_RP, 5'd2, 1'b1, 8'hFF, "R3", "w2 hi unstaged");
    read_chk(C_RP, 5'd0, 1'b0, 8'hFF, "R3", "w0 unstaged");
    issue(C_CM, 5'd4, 1'b0, 8'h00);
    busy_left(c);
    read_chk(C_RP, 5'd5, 1'b0, 8'hFF, "R9", "empty buffer commit lo");
    read_chk(C_RP, 5'd7, 1'b1, 8'hFF, "R9", "empty buffer commit hi");
  endtask

  task automatic t_byte_write();
    int c;
    issue(C_BW, 5'd4, 1'b0, 8'h11);
    busy_left(c);
    issue(C_BW, 5'd3, 1'b0, 8'h5A);
    read_chk(C_RD, 5'd3, 1'b0, 8'hFF, "R5", "poll addr 3");
    read_chk(C_RD, 5'd4, 1'b0, 8'h11, "R5", "neighbour addr 4");
    busy_left(c);
    check("R5", "byte busy cycles", 32'(c + 2), 32'(TB));
    read_chk(C_RD, 5'd3, 1'b0, 8'h5A, "R5", "addr 3 written");
    issue(C_BW, 5'd3, 1'b0, 8'hA5);
    busy_left(c);
    read_chk(C_RD, 5'd3, 1'b0, 8'hA5, "R5", "overwrite without erase");
  endtask

  task automatic t_drop_busy();
    int c;
    issue(C_BW, 5'd7, 1'b0, 8'h77);
    check("R7", "err before drop", 32'(err_sticky), 0);
    issue(C_BW, 5'd8, 1'b0, 8'h88);
    check("R7", "err after drop", 32'(err_sticky), 1);
    issue(C_CM, 5'd8, 1'b0, 8'h00);
    issue(C_LD, 5'd8, 1'b0, 8'h42);
    issue(C_ER, 5'd0, 1'b0, 8'h00);
    busy_left(c);
    check("R7", "timer unaffected", 32'(c + 4), 32'(TB));
    read_chk(C_RD, 5'd8, 1'b0, 8'hFF, "R7", "dropped byte write");
    read_chk(C_RD, 5'd7, 1'b0, 8'h77, "R7", "accepted byte write");
    read_chk(C_RD, 5'd3, 1'b0, 8'hA5, "R7", "dropped erase");
    issue(C_CM, 5'd8, 1'b0, 8'h00);
    busy_left(c);
    read_chk(C_RP, 5'd8, 1'b0, 8'hFF, "R7", "dropped load");
    check("R7", "err sticky", 32'(err_sticky), 1);
  endtask

  task automatic t_erase();
    int c;
    issue(C_ER, 5'd0, 1'b0, 8'h00);
    read_chk(C_RD, 5'd7, 1'b0, 8'hFF, "R6", "data during erase");
    read_chk(C_RP, 5'd2, 1'b0, 8'hFF, "R6", "prog during erase");
    busy_left(c);
    check("R6", "erase busy cycles", 32'(c + 2), 32'(TE));
    read_chk(C_RD, 5'd3, 1'b0, 8'hFF, "R6", "data 3 erased");
    read_chk(C_RD, 5'd4, 1'b0, 8'hFF, "R6", "data 4 erased");
    read_chk(C_RP, 5'd2, 1'b0, 8'hFF, "R6", "prog w2 erased");
    read_chk(C_RP, 5'd6, 1'b1, 8'hFF, "R6", "prog w6 erased");
  endtask

  task automatic t_bad_ops();
    issue(3'd6, 5'd3, 1'b0, 8'h00);
    check("R10", "op6 rd_valid", 32'(rd_valid), 0);
    check("R10", "op6 busy", 32'(busy), 0);
    issue(3'd7, 5'd3, 1'b0, 8'h12);
    check("R10", "op7 rd_valid", 32'(rd_valid), 0);
    check("R10", "op7 busy", 32'(busy), 0);
    read_chk(C_RD, 5'd3, 1'b0, 8'hFF, "R10", "op7 wrote nothing");
  endtask

  task automatic t_rereset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", "err cleared by reset", 32'(err_sticky), 0);
    check("R1", "busy after reset", 32'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page_commit();
    t_other_page();
    t_byte_write();
    t_drop_busy();
    t_erase();
    t_bad_ops();
    t_rereset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule